// File: doc/BRIEF.md
# Status Register and Write-Protection Unit

This block keeps the state that guards a small serial non-volatile memory against unwanted writes. It holds the write-enable latch, a two-bit protect-size field and the busy indication, and it forms the byte that a status read returns. A protocol engine feeds it one-cycle strobes that are already decoded from the serial frame. The block answers with two flags: whether a write may proceed now, and whether the address presented by the engine lies inside the protected region.

The protect-size field models non-volatile storage. The functional reset clears the enable latch and leaves the protect field alone. Only a separate factory-default reset returns the field to zero. The protect field seen by a status read is a shadow copy. The shadow holds its value while an internal write cycle runs, so a write to the protect field becomes readable only after that cycle ends. The latch and busy bits in the same byte keep tracking live.

Top module: `wp_status_unit`

## Requirements
- R1: The status byte `sts_byte` is {4'b1111, prot_rd[1:0], wel, busy}. Bit 1 is the enable latch. Bit 0 equals `cyc_active` in the same cycle. Bits 3:2 are the readable protect field.
- R2: A `set_wel` strobe sets the enable latch on the next clock edge when `wp_n` is high and no clear strobe is present.
- R3: A `clr_wel` strobe or a `cyc_done` strobe clears the enable latch. A clear wins over a `set_wel` in the same cycle.
- R4: While `wp_n` is low, the latch clears at the next edge and `wr_permit` is low. `wr_permit` is high only when the latch is set, `wp_n` is high and `cyc_active` is low.
- R5: `addr_prot` uses the stored protect field. Code 00 protects nothing. Code 01 protects the top quarter, where the two top address bits are 11. Code 10 protects the top half, where the top address bit is 1. Code 11 protects every address.
- R6: A `sr_wr` strobe copies `sr_wdata[3:2]` into the stored protect field only when `wr_permit` is high in that cycle. A status write never changes the enable latch.
- R7: While `cyc_active` is high, the readable protect field keeps its value. When `cyc_active` is low, the field takes on the stored value one cycle later.
- R8: The functional reset `por_n` clears the enable latch and keeps the protect field. The factory reset `fdef_n` sets the protect field to 00, so the status byte reads 0xF0 once both resets are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low functional (power-on) reset |
| fdef_n | input | 1 | Active-low factory-default reset of the protect field |
| set_wel | input | 1 | Strobe: set the enable latch |
| clr_wel | input | 1 | Strobe: clear the enable latch |
| sr_wr | input | 1 | Strobe: status write committed by the frame logic |
| sr_wdata | input | 8 | Data byte of the status write |
| cyc_done | input | 1 | Strobe: an internal write cycle finished |
| cyc_active | input | 1 | An internal write cycle is running |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| tgt_addr | input | 9 | Target address of an array access |
| sts_byte | output | 8 | Readable status byte |
| wr_permit | output | 1 | A write may proceed |
| addr_prot | output | 1 | `tgt_addr` lies in the protected region |

## Verification
Two events can fall in the same cycle here. A status write can coincide with the protect pin going low. A set strobe can coincide with a clear strobe. The bench drives each pair in one vector. For the first pair it then checks that the protect field kept its old value and that the latch is clear. For the second pair it checks that the latch ended clear. A third case issues a status write during an active cycle. The bench checks that the write is refused and that the readable field stays frozen until the cycle ends.

// File: rtl/sr_pkg.sv
package sr_pkg;
    localparam int STS_W  = 8;
    localparam int PROT_W = 2;

    typedef enum logic [PROT_W-1:0] {
        PROT_NONE    = 2'b00,
        PROT_QUARTER = 2'b01,
        PROT_HALF    = 2'b10,
        PROT_ALL     = 2'b11
    } prot_code_e;

    typedef struct packed {
        logic wel;
    } live_st_t;

    typedef struct packed {
        prot_code_e prot;
        prot_code_e prot_rd;
    } nv_st_t;
endpackage

// File: rtl/sr_prot_map.sv
module sr_prot_map
    import sr_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  prot_code_e        code,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (code)
            PROT_NONE:    hit = 1'b0;
            PROT_QUARTER: hit = addr[TOP] & addr[TOP-1];
            PROT_HALF:    hit = addr[TOP];
            default:      hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_byte_pack.sv
module sr_byte_pack
    import sr_pkg::*;
(
    input  prot_code_e       prot_rd,
    input  logic             wel,
    input  logic             busy,
    output logic [STS_W-1:0] sts
);
    localparam int PAD_W = STS_W - PROT_W - 2;

    always_comb begin
        sts = {{PAD_W{1'b1}}, prot_rd, wel, busy};
    end
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit
    import sr_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              fdef_n,
    input  logic              set_wel,
    input  logic              clr_wel,
    input  logic              sr_wr,
    input  logic [7:0]        sr_wdata,
    input  logic              cyc_done,
    input  logic              cyc_active,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] tgt_addr,
    output logic [7:0]        sts_byte,
    output logic              wr_permit,
    output logic              addr_prot
);
    localparam int BP_LSB = 2;

    live_st_t live_d, live_q;
    nv_st_t   nv_d, nv_q;
    logic     permit;

    always_comb begin
        permit = live_q.wel & wp_n & ~cyc_active;

        live_d = live_q;
        if (!wp_n || clr_wel || cyc_done) begin
            live_d.wel = 1'b0;
        end else if (set_wel) begin
            live_d.wel = 1'b1;
        end

        nv_d = nv_q;
        if (sr_wr && permit) begin
            nv_d.prot = prot_code_e'(sr_wdata[BP_LSB +: PROT_W]);
        end
        if (!cyc_active) begin
            nv_d.prot_rd = nv_q.prot;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            live_q <= '0;
        end else begin
            live_q <= live_d;
        end
    end

    always_ff @(posedge clk or negedge fdef_n) begin
        if (!fdef_n) begin
            nv_q <= '{prot: PROT_NONE, prot_rd: PROT_NONE};
        end else begin
            nv_q <= nv_d;
        end
    end

    sr_prot_map #(.ADDR_W(ADDR_W)) u_map (
        .code (nv_q.prot),
        .addr (tgt_addr),
        .hit  (addr_prot)
    );

    sr_byte_pack u_pack (
        .prot_rd (nv_q.prot_rd),
        .wel     (live_q.wel),
        .busy    (cyc_active),
        .sts     (sts_byte)
    );

    assign wr_permit = permit;
endmodule

// File: rtl/wp_status_unit_chk.sv
module wp_status_unit_chk (
    input logic       clk,
    input logic       por_n,
    input logic       fdef_n,
    input logic       set_wel,
    input logic       clr_wel,
    input logic       sr_wr,
    input logic       cyc_done,
    input logic       cyc_active,
    input logic       wp_n,
    input logic [7:0] sts_byte,
    input logic       wr_permit,
    input logic       addr_prot,
    input logic [1:0] bp_store
);
    // R4
    wel_drop_chk: assert property (@(posedge clk) disable iff (!por_n)
        !wp_n |=> !sts_byte[1]);

    // R4
    permit_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
        wr_permit |-> (wp_n && !cyc_active && sts_byte[1]));

    // R3
    clear_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
        (clr_wel || cyc_done) |=> !sts_byte[1]);

    // R2
    wel_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        (set_wel && wp_n && !clr_wel && !cyc_done) |=> sts_byte[1]);

    // R7
    frozen_bp_chk: assert property (@(posedge clk) disable iff (!por_n || !fdef_n)
        (cyc_active && $past(cyc_active)) |-> $stable(sts_byte[3:2]));

    // R5
    all_prot_chk: assert property (@(posedge clk) disable iff (!fdef_n)
        (bp_store == 2'b11) |-> addr_prot);

    // R6
    refused_wr_chk: assert property (@(posedge clk) disable iff (!por_n || !fdef_n)
        (sr_wr && !wr_permit) |=> $stable(bp_store));

    // R1
    busy_bit_chk: assert property (@(posedge clk) disable iff (!por_n)
        sts_byte[0] == cyc_active);
endmodule

bind wp_status_unit wp_status_unit_chk u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .fdef_n     (fdef_n),
    .set_wel    (set_wel),
    .clr_wel    (clr_wel),
    .sr_wr      (sr_wr),
    .cyc_done   (cyc_done),
    .cyc_active (cyc_active),
    .wp_n       (wp_n),
    .sts_byte   (sts_byte),
    .wr_permit  (wr_permit),
    .addr_prot  (addr_prot),
    .bp_store   (nv_q.prot)
);

// File: tb/sim_wp_status_unit.sv
module sim_wp_status_unit;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       fdef_n = 1'b0;
    logic       set_wel = 1'b0;
    logic       clr_wel = 1'b0;
    logic       sr_wr = 1'b0;
    logic [7:0] sr_wdata = 8'h00;
    logic       cyc_done = 1'b0;
    logic       cyc_active = 1'b0;
    logic       wp_n = 1'b1;
    logic [8:0] tgt_addr = 9'h000;
    logic [7:0] sts_byte;
    logic       wr_permit;
    logic       addr_prot;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    wp_status_unit u0 (
        .clk(clk), .por_n(por_n), .fdef_n(fdef_n), .set_wel(set_wel),
        .clr_wel(clr_wel), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
        .cyc_done(cyc_done), .cyc_active(cyc_active), .wp_n(wp_n),
        .tgt_addr(tgt_addr), .sts_byte(sts_byte), .wr_permit(wr_permit),
        .addr_prot(addr_prot)
    );

    typedef struct packed {
        logic       set, clr, sw, done, act, wpn;
        logic [7:0] data;
        logic [8:0] addr;
        logic [7:0] est;
        logic       eperm, eprot;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        '{1,0,0,0,0,1, 8'h00, 9'h1FF, 8'hF2, 1, 0}, // R2 set latch
        '{0,0,1,0,0,1, 8'h04, 9'h180, 8'hF2, 1, 1}, // R6 bp=01, R5 quarter
        '{0,0,0,0,1,1, 8'h00, 9'h17F, 8'hF3, 0, 0}, // R7 cycle starts, R1 busy bit
        '{0,0,1,0,1,1, 8'h0C, 9'h180, 8'hF3, 0, 1}, // R6 refused while busy
        '{0,0,0,1,0,1, 8'h00, 9'h100, 8'hF4, 0, 0}, // R3 done clears, R7 shadow updates
        '{1,0,0,0,0,1, 8'h00, 9'h000, 8'hF6, 1, 0}, // R2
        '{0,0,0,0,0,0, 8'h00, 9'h000, 8'hF4, 0, 0}, // R4 pin low
        '{1,1,0,0,0,1, 8'h00, 9'h000, 8'hF4, 0, 0}, // R3 clear beats set
        '{1,0,0,0,0,1, 8'h00, 9'h0FF, 8'hF6, 1, 0}, // R2
        '{0,0,1,0,0,1, 8'hFB, 9'h100, 8'hF6, 1, 1}, // R6 bp=10, R5 half
        '{0,0,0,0,0,1, 8'h00, 9'h0FF, 8'hFA, 1, 0}, // R7 shadow follows
        '{0,0,1,0,0,0, 8'h0C, 9'h000, 8'hF8, 0, 0}, // R4 write with pin low blocked
        '{1,0,0,0,0,1, 8'h00, 9'h000, 8'hFA, 1, 0}, // R2
        '{0,0,1,0,0,1, 8'h0C, 9'h000, 8'hFA, 1, 1}, // R6 bp=11, R5 all
        '{0,0,0,0,0,1, 8'h00, 9'h000, 8'hFE, 1, 1}  // R1 layout
    };

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R8 reset state
        chk("R8 reset status", {2'b0, sts_byte}, 10'h0F0);
        chk("R4 reset permit", {9'b0, wr_permit}, 10'h000);
        por_n = 1'b1;
        fdef_n = 1'b1;
        @(negedge clk);
        chk("R8 idle after reset", {2'b0, sts_byte}, 10'h0F0);

        for (int i = 0; i < NV; i++) begin
            set_wel = VT[i].set; clr_wel = VT[i].clr; sr_wr = VT[i].sw;
            cyc_done = VT[i].done; cyc_active = VT[i].act; wp_n = VT[i].wpn;
            sr_wdata = VT[i].data; tgt_addr = VT[i].addr;
            step();
            chk("R1/R7 vector status", {2'b0, sts_byte}, {2'b0, VT[i].est});
            chk("R4 vector permit", {9'b0, wr_permit}, {9'b0, VT[i].eperm});
            chk("R5 vector protect", {9'b0, addr_prot}, {9'b0, VT[i].eprot});
        end

        // R5 quarter boundary: bp=11 now; check 0x17F under bp=01
        set_wel = 1'b1; step(); set_wel = 1'b0;
        sr_wr = 1'b1; sr_wdata = 8'h04; step(); sr_wr = 1'b0;
        tgt_addr = 9'h17F; #0;
        @(negedge clk);
        chk("R5 below quarter", {9'b0, addr_prot}, 10'h000);
        tgt_addr = 9'h180;
        @(posedge clk); @(negedge clk);
        chk("R5 quarter start", {9'b0, addr_prot}, 10'h001);

        // R8 functional reset keeps protect field (01), clears latch
        chk("R8 pre-reset status", {2'b0, sts_byte}, 10'h0F6);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        chk("R8 por keeps bp", {2'b0, sts_byte}, 10'h0F4);

        // R8 factory default
        fdef_n = 1'b0;
        @(negedge clk);
        fdef_n = 1'b1;
        @(negedge clk);
        chk("R8 factory default", {2'b0, sts_byte}, 10'h0F0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule